// File: doc/BRIEF.md
# Hit and Frame Word Formatter

This block turns time-stamped hit records, taken from a readout FIFO over a valid/ready stream, into fixed 48-bit output words. Each word marks itself as data or status with its top bit. A hit word packs the pixel-group index, a one-hot pixel select within the arbiter, the pileup field, and the leading and trailing coarse and fine times with their range selectors.

A free-running tick counter splits time into frames of `FRAME_TICKS` clock cycles. At each frame edge the block takes a snapshot of its per-frame statistics and then sends two status words ahead of any waiting hit. The statistics are the count of upset events, the count of hit words sent, the count of group-collision events, a checksum over all words sent, and the frame number. Comma, idle and sync insertion, line coding and serialization all happen downstream.

The arbiter select can be supplied already one-hot, or as a small binary index that the block expands. A parameter picks which.

Top module: `hfmt_formatter`

## Requirements
- R1: A hit word has bit 47 = 0. Bits 46..40 hold the group index, 39..35 the one-hot pixel select, 34..30 the pileup field, and bit 29 the leading selector. Bits 28..17 hold the leading coarse time, 16..12 the leading fine time, bit 11 the trailing selector, 10..5 the trailing coarse time and 4..0 the trailing fine time.
- R2: With `ARB_BINARY`=1, an arbiter index k in 0..4 sets only bit 35+k of the word. An index of 5 or more gives an all-zero select field. With `ARB_BINARY`=0 the 5-bit input is copied as given.
- R3: The first status word has bit 47 = 1 and carries the frame number in bits 27..0, the hit-word count in bits 40..28 and the upset count in bits 46..41. All three refer to the frame that just ended. Frames are numbered from 0 after reset, and frame n ends at clock edge (n+1)*FRAME_TICKS-1 counted from the first edge after reset.
- R4: The second status word has bit 47 = 1, the checksum in bits 46..31, the collision count in bits 5..0, and zeros in bits 30..6. It always follows the first status word directly.
- R5: The checksum is the XOR of bits 47..32, 31..16 and 15..0 of every word handed over during the frame. This includes status words sent in that frame.
- R6: The upset, hit and collision counters stop at their all-ones value (63, 8191, 63) rather than wrap.
- R7: An event, or a word handed over, on the clock edge that ends a frame is counted in the new frame.
- R8: Status words go out before any pending hit. In the cycle after a frame edge, `hit_ready` is low.
- R9: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` holds its value.
- R10: After reset, `word_valid` is low and `hit_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one frame tick per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_valid | input | 1 | Hit record offered |
| hit_ready | output | 1 | Hit record taken on this edge |
| hit_group | input | 7 | Pixel-group index (column*9+group) |
| hit_arb | input | ARB_W | Pixel select: 3-bit index or 5-bit one-hot |
| hit_pileup | input | 5 | Pileup address |
| lead_sel | input | 1 | Leading coarse selector |
| lead_coarse | input | 12 | Leading coarse time with rollover bit |
| lead_fine | input | 5 | Leading fine time |
| trail_sel | input | 1 | Trailing coarse selector |
| trail_coarse | input | 6 | Trailing coarse time |
| trail_fine | input | 5 | Trailing fine time |
| seu_evt | input | 1 | One upset event this cycle |
| coll_evt | input | 1 | One group collision this cycle |
| word_valid | output | 1 | Output word present |
| word_ready | input | 1 | Downstream takes the word |
| word_data | output | 48 | Output word |

## Verification
The bench builds the block with `FRAME_TICKS`=150 and `ARB_BINARY`=1. The short frame means five frame edges fit in a short run, and a burst of 80 upset pulses inside one frame drives the 6-bit counter into its ceiling. The binary select variant lets the bench reach both the in-range one-hot codes and the out-of-range indices that must clear the field. Upset and collision pulses placed exactly on a frame edge, together with random output backpressure, exercise the new-frame attribution rule, the checksum over status words, and the holding of data under backpressure.

// File: rtl/hfmt_pkg.sv
package hfmt_pkg;
   localparam int WORD_W = 48;
   localparam int SEU_W  = 6;
   localparam int HITS_W = 13;
   localparam int COLL_W = 6;
   localparam int FRM_W  = 28;
   localparam int CK_W   = 16;
   localparam int PAD_W  = WORD_W - 1 - CK_W - COLL_W;

   typedef enum logic [1:0] {ST_IDLE, ST_W0, ST_W1} stat_st_t;

   function automatic logic [CK_W-1:0] fold16(input logic [WORD_W-1:0] w);
      return w[47:32] ^ w[31:16] ^ w[15:0];
   endfunction
endpackage

// File: rtl/hfmt_pack.sv
module hfmt_pack #(
   parameter bit ARB_BINARY = 1'b0,
   parameter int ARB_W      = ARB_BINARY ? 3 : 5
) (
   input  logic [6:0]  grp,
   input  logic [ARB_W-1:0] arb,
   input  logic [4:0]  pile,
   input  logic        lsel,
   input  logic [11:0] lcrs,
   input  logic [4:0]  lfine,
   input  logic        tsel,
   input  logic [5:0]  tcrs,
   input  logic [4:0]  tfine,
   output logic [hfmt_pkg::WORD_W-1:0] word
);
   logic [4:0] arb_oh;

   generate
      if (ARB_BINARY) begin : g_bin
         for (genvar k = 0; k < 5; k++) begin : g_bit
            assign arb_oh[k] = (arb == ARB_W'(k));
         end
      end else begin : g_oh
         assign arb_oh = arb[4:0];
      end
   endgenerate

   assign word = {1'b0, grp, arb_oh, pile, lsel, lcrs, lfine, tsel, tcrs, tfine};
endmodule

// File: rtl/hfmt_frame_timer.sv
module hfmt_frame_timer #(
   parameter int FRAME_TICKS = 2048,
   parameter int FRM_W       = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             frame_edge,
   output logic [FRM_W-1:0] frm_snap
);
   localparam int TICK_W = $clog2(FRAME_TICKS);
   localparam logic [TICK_W-1:0] LAST = TICK_W'(FRAME_TICKS - 1);

   logic [TICK_W-1:0] tick_q;
   logic [FRM_W-1:0]  frm_q;

   assign frame_edge = (tick_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q   <= '0;
         frm_q    <= '0;
         frm_snap <= '0;
      end else if (frame_edge) begin
         tick_q   <= '0;
         frm_snap <= frm_q;
         frm_q    <= frm_q + 1'b1;
      end else begin
         tick_q   <= tick_q + 1'b1;
      end
   end
endmodule

// File: rtl/hfmt_satcnt.sv
module hfmt_satcnt #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic [W-1:0] snap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         snap <= '0;
      end else if (clr) begin
         snap <= cnt;
         cnt  <= {{(W-1){1'b0}}, inc};
      end else if (inc && (cnt != {W{1'b1}})) begin
         cnt  <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hfmt_formatter.sv
module hfmt_formatter
   import hfmt_pkg::*;
#(
   parameter int FRAME_TICKS = 2048,
   parameter bit ARB_BINARY  = 1'b0,
   localparam int ARB_W      = ARB_BINARY ? 3 : 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_valid,
   output logic              hit_ready,
   input  logic [6:0]        hit_group,
   input  logic [ARB_W-1:0]  hit_arb,
   input  logic [4:0]        hit_pileup,
   input  logic              lead_sel,
   input  logic [11:0]       lead_coarse,
   input  logic [4:0]        lead_fine,
   input  logic              trail_sel,
   input  logic [5:0]        trail_coarse,
   input  logic [4:0]        trail_fine,
   input  logic              seu_evt,
   input  logic              coll_evt,
   output logic              word_valid,
   input  logic              word_ready,
   output logic [WORD_W-1:0] word_data
);
   generate
      if (FRAME_TICKS < 8) begin : g_bad_frame
         $error("FRAME_TICKS must be at least 8");
      end
   endgenerate

   logic              frame_edge;
   logic [FRM_W-1:0]  frm_snap;
   logic [WORD_W-1:0] hit_word;
   logic [SEU_W-1:0]  seu_cnt, seu_snap;
   logic [HITS_W-1:0] hits_cnt, hits_snap;
   logic [COLL_W-1:0] coll_cnt, coll_snap;
   logic [CK_W-1:0]   ck_q, ck_snap;
   stat_st_t          st_q;
   logic              load, out_fire;

   hfmt_frame_timer #(.FRAME_TICKS(FRAME_TICKS), .FRM_W(FRM_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .frame_edge(frame_edge), .frm_snap(frm_snap));

   hfmt_pack #(.ARB_BINARY(ARB_BINARY), .ARB_W(ARB_W)) u_pack (
      .grp(hit_group), .arb(hit_arb), .pile(hit_pileup), .lsel(lead_sel),
      .lcrs(lead_coarse), .lfine(lead_fine), .tsel(trail_sel),
      .tcrs(trail_coarse), .tfine(trail_fine), .word(hit_word));

   assign out_fire = word_valid && word_ready;
   assign load     = !word_valid || word_ready;
   assign hit_ready = load && (st_q == ST_IDLE);

   hfmt_satcnt #(.W(SEU_W)) u_seu (
      .clk(clk), .rst_n(rst_n), .clr(frame_edge), .inc(seu_evt),
      .cnt(seu_cnt), .snap(seu_snap));
   hfmt_satcnt #(.W(HITS_W)) u_hits (
      .clk(clk), .rst_n(rst_n), .clr(frame_edge), .inc(out_fire && !word_data[WORD_W-1]),
      .cnt(hits_cnt), .snap(hits_snap));
   hfmt_satcnt #(.W(COLL_W)) u_coll (
      .clk(clk), .rst_n(rst_n), .clr(frame_edge), .inc(coll_evt),
      .cnt(coll_cnt), .snap(coll_snap));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_q    <= '0;
         ck_snap <= '0;
      end else if (frame_edge) begin
         ck_snap <= ck_q;
         ck_q    <= out_fire ? fold16(word_data) : '0;
      end else if (out_fire) begin
         ck_q    <= ck_q ^ fold16(word_data);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         word_valid <= 1'b0;
         word_data  <= '0;
      end else begin
         if (load) begin
            unique case (st_q)
               ST_W0: begin
                  word_valid <= 1'b1;
                  word_data  <= {1'b1, seu_snap, hits_snap, frm_snap};
               end
               ST_W1: begin
                  word_valid <= 1'b1;
                  word_data  <= {1'b1, ck_snap, {PAD_W{1'b0}}, coll_snap};
               end
               default: begin
                  word_valid <= hit_valid;
                  if (hit_valid) word_data <= hit_word;
               end
            endcase
         end
         if (frame_edge)                  st_q <= ST_W0;
         else if (load && st_q == ST_W0)  st_q <= ST_W1;
         else if (load && st_q == ST_W1)  st_q <= ST_IDLE;
      end
   end
endmodule

// File: rtl/hfmt_checker.sv
module hfmt_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        hit_ready,
   input logic        word_valid,
   input logic        word_ready,
   input logic [47:0] word_data,
   input logic        frame_edge,
   input logic [5:0]  seu_cnt
);
   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

   // R2
   arb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !word_data[47]) |-> $onehot0(word_data[39:35]));

   // R8
   status_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_edge |=> !hit_ready);

   // R6
   seu_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seu_cnt == 6'h3f && !frame_edge) |=> (seu_cnt == 6'h3f));

   // R3
   frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_edge |=> !frame_edge);
endmodule

bind hfmt_formatter hfmt_checker u_hfmt_chk (
   .clk(clk), .rst_n(rst_n), .hit_ready(hit_ready), .word_valid(word_valid),
   .word_ready(word_ready), .word_data(word_data), .frame_edge(frame_edge),
   .seu_cnt(seu_cnt));

// File: tb/test_hfmt_formatter.sv
module test_hfmt_formatter;
   localparam int FT = 150;
   localparam int NFRAMES = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hit_valid = 1'b0, hit_ready;
   logic [6:0] hit_group = '0;
   logic [2:0] hit_arb = '0;
   logic [4:0] hit_pileup = '0;
   logic lead_sel = 1'b0, trail_sel = 1'b0;
   logic [11:0] lead_coarse = '0;
   logic [4:0] lead_fine = '0, trail_fine = '0;
   logic [5:0] trail_coarse = '0;
   logic seu_evt = 1'b0, coll_evt = 1'b0;
   logic word_valid, word_ready = 1'b1;
   logic [47:0] word_data;

   int checks = 0, fails = 0, edges = 0;
   logic [47:0] exp_q[$];
   int tag_q[$];
   bit stop_drive = 0;

   always #4 clk = ~clk;

   hfmt_formatter #(.FRAME_TICKS(FT), .ARB_BINARY(1'b1)) i_hfmt_formatter (
      .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
      .hit_group(hit_group), .hit_arb(hit_arb), .hit_pileup(hit_pileup),
      .lead_sel(lead_sel), .lead_coarse(lead_coarse), .lead_fine(lead_fine),
      .trail_sel(trail_sel), .trail_coarse(trail_coarse), .trail_fine(trail_fine),
      .seu_evt(seu_evt), .coll_evt(coll_evt), .word_valid(word_valid),
      .word_ready(word_ready), .word_data(word_data));

   function automatic logic [15:0] xf(input logic [47:0] w);
      return w[47:32] ^ w[31:16] ^ w[15:0];
   endfunction

   // R1 R2: expected hit word from the field layout
   function automatic logic [47:0] exp_hit();
      logic [4:0] oh;
      oh = (hit_arb < 3'd5) ? (5'b1 << hit_arb) : 5'b0;
      return {1'b0, hit_group, oh, hit_pileup, lead_sel, lead_coarse, lead_fine,
              trail_sel, trail_coarse, trail_fine};
   endfunction

   task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(posedge clk) if (rst_n) edges++;

   // monitor / scoreboard
   logic [5:0]  m_seu = 0, m_coll = 0;
   logic [12:0] m_hits = 0;
   logic [15:0] m_ck = 0;
   bit prev_stall = 0, stall_chk = 0;
   logic [47:0] prev_data;
   always @(negedge clk) begin
      if (rst_n) begin
         int nxt;
         bit bnd;
         logic [47:0] w0, w1;
         nxt = edges;
         bnd = (nxt % FT) == FT - 1;
         if (stall_chk) begin
            check(hit_ready == 1'b0, "R8", {47'b0, hit_ready}, 48'd0);
            stall_chk = 0;
         end
         if (prev_stall)
            check(word_valid && word_data == prev_data, "R9", word_data, prev_data);
         if (bnd) begin
            w0 = {1'b1, m_seu, m_hits, 28'(nxt / FT)};
            w1 = {1'b1, m_ck, 25'b0, m_coll};
            m_seu = 0; m_coll = 0; m_hits = 0; m_ck = 0;
         end
         // R6 R7: saturating counts, boundary-edge events go to the new frame
         if (seu_evt && m_seu != 6'h3f) m_seu++;
         if (coll_evt && m_coll != 6'h3f) m_coll++;
         if (word_valid && word_ready) begin
            m_ck = m_ck ^ xf(word_data);
            if (!word_data[47] && m_hits != 13'h1fff) m_hits++;
            if (exp_q.size() == 0) check(1'b0, "R1 R3 queue", word_data, 48'd0);
            else begin
               logic [47:0] e;
               int t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (t == 1) check(word_data == e, "R1 R2", word_data, e);
               else if (t == 3) check(word_data == e, "R3 R6 R7", word_data, e);
               else check(word_data == e, "R4 R5", word_data, e);
            end
         end
         if (hit_valid && hit_ready) begin
            exp_q.push_back(exp_hit()); tag_q.push_back(1);
         end
         if (bnd) begin
            exp_q.push_back(w0); tag_q.push_back(3);
            exp_q.push_back(w1); tag_q.push_back(4);
            stall_chk = 1;
         end
         prev_stall = word_valid && !word_ready;
         prev_data = word_data;
      end
   end

   task automatic send_hit(input int i);
      hit_valid    = 1'b1;
      hit_group    = 7'(i % 90);
      hit_arb      = 3'(i % 8);
      hit_pileup   = 5'($urandom);
      lead_sel     = 1'($urandom);
      lead_coarse  = (i % 7 == 0) ? 12'hfff : 12'($urandom);
      lead_fine    = 5'($urandom);
      trail_sel    = 1'($urandom);
      trail_coarse = (i % 5 == 0) ? 6'h3f : 6'($urandom);
      trail_fine   = 5'($urandom);
      @(negedge clk);
      while (!hit_ready) @(negedge clk);
      @(posedge clk); #2;
      hit_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R10
      check(word_valid == 1'b0, "R10", {47'b0, word_valid}, 48'd0);
      check(hit_ready == 1'b1, "R10", {47'b0, hit_ready}, 48'd1);
      fork
         begin : hits
            for (int i = 0; i < 260; i++) begin
               send_hit(i);
               repeat ($urandom % 3) begin @(posedge clk); #2; end
               if (edges > NFRAMES * FT - 20) break;
            end
         end
         begin : events
            while (edges < NFRAMES * FT) begin
               @(posedge clk); #2;
               seu_evt  = (edges >= 160 && edges < 240) || edges == 3 * FT - 1;
               coll_evt = (edges >= 170 && edges < 180) || edges == 3 * FT - 1 || edges == 600;
            end
            seu_evt = 1'b0; coll_evt = 1'b0;
         end
         begin : backpressure
            while (edges < NFRAMES * FT + 20) begin
               @(posedge clk); #2;
               word_ready = (edges < FT) ? 1'b1 : ($urandom % 4 != 0);
            end
            word_ready = 1'b1;
         end
      join
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R3 R4 drain", 48'(exp_q.size()), 48'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(8 * 20000);
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule